// File: doc/BRIEF.md
# Seven-Channel Register-Programmed PWM Generator

This block produces seven independent pulse-width-modulated outputs from a small bank of memory-mapped registers. Channels 0 to 5 are meant for external pins and channel 6 feeds logic inside the chip. Each channel counts single-cycle tick strobes taken from one of five source tick inputs. All sources share the system clock domain and stand in for slower source clocks. A channel drives its output high for a programmed number of ticks and then low for another programmed number, repeating without end. In bypass mode it instead passes the chosen tick strobe straight to its output.

A host brings a channel up in a fixed order. It first picks the source while the channel's counter enable is clear. It then sets the counter enable, then the output-stage enable, and finally the pin enable. It tears the channel down in the reverse order. Phase lengths are stored minus one, so a phase always lasts at least one tick. New phase lengths take effect only at the start of the next period. The total divide ratio therefore runs from 2 to 131072 source ticks.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero and all seven outputs are low.
- R2: Registers are at byte offsets 0x00 (source/bypass, 28 bits), 0x04 (pin enable and transition-mode, 14 bits), 0x08 (counter enable, 7 bits), 0x0C (output-stage enable, 7 bits), 0x10+8n (channel n high count minus one, 16 bits) and 0x14+8n (channel n low count minus one, 16 bits). A write takes effect at the next clock edge. Reads are combinational and return the stored value with unimplemented bits as zero. Any other address, including unaligned ones, reads zero, and a write to it changes nothing.
- R3: Bits [3n+2:3n] of register 0x00 select channel n's source. Values 0 to 4 pick `src_tick[value]`. Values 5 to 7 pick no source, so the channel's phase and count stay frozen.
- R4: With bypass clear and all three enables set, the output is high for (high count + 1) selected ticks and then low for (low count + 1) ticks, repeating. The first period after the counter enable rises starts with the high phase.
- R5: While counter enable bit n (register 0x08) is clear, channel n is held at the start of its high phase, with its period lengths reloaded from the registers.
- R6: Output n is low whenever bit n of register 0x04, bit n of 0x08 or bit n of 0x0C is clear.
- R7: When bit 21+n of register 0x00 is set and all three enables are set, output n equals the selected tick strobe in the same cycle, and the counter is held.
- R8: A change to a channel's high or low count written during a period does not alter that period. The new values apply from the next high phase.
- R9: Bits 7 to 13 of register 0x04 (transition-mode, one per channel) are stored and read back but do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wr_en | input | 1 | Write strobe, one write per asserted cycle |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| src_tick | input | 5 | Single-cycle source tick strobes |
| pwm_out | output | 7 | Channel outputs, bit n for channel n |

## Verification
Both `reg_rd_data` and `pwm_out` are combinational from the stored state and the current inputs. A register write therefore shows on the read port, and on the output gating, starting in the cycle after the edge that takes the write. In bypass mode a tick shows on the output in the same cycle it arrives. In counting mode a phase change shows in the cycle after the edge that consumes the last tick of a phase. The bench drives inputs just after a rising edge and compares both outputs against its own tick-counting model at every falling edge. The model advances once per falling edge, using the inputs that the next rising edge will see.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int NUM_CH     = 7;
    localparam int NUM_SRC    = 5;
    localparam int SEL_W      = 3;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;

    // derived field layout
    localparam int BYP_LSB    = SEL_W * NUM_CH;
    localparam int SRC_BITS   = BYP_LSB + NUM_CH;
    localparam int TMODE_LSB  = NUM_CH;
    localparam int OE_BITS    = 2 * NUM_CH;
    localparam int CNT_STRIDE = 8;

    localparam logic [ADDR_W-1:0] A_SRC      = 8'h00;
    localparam logic [ADDR_W-1:0] A_OE       = 8'h04;
    localparam logic [ADDR_W-1:0] A_PRE      = 8'h08;
    localparam logic [ADDR_W-1:0] A_POST     = 8'h0C;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h10;
    localparam int                CNT_END    = 16 + CNT_STRIDE * NUM_CH;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             bypass;
        logic             pre_en;
        logic             post_en;
        logic             out_en;
        logic [CNT_W-1:0] hi_m1;
        logic [CNT_W-1:0] lo_m1;
    } chan_cfg_t;

    function automatic logic pick_tick(input logic [SEL_W-1:0] sel,
                                       input logic [NUM_SRC-1:0] ticks);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) r = ticks[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output chan_cfg_t [NUM_CH-1:0]       cfg
);

    logic [SRC_BITS-1:0] src_q;
    logic [OE_BITS-1:0]  oe_q;
    logic [NUM_CH-1:0]   pre_q;
    logic [NUM_CH-1:0]   post_q;
    logic [CNT_W-1:0]    hi_q [NUM_CH];
    logic [CNT_W-1:0]    lo_q [NUM_CH];

    // per-channel count register decode
    logic [ADDR_W-1:0]   cnt_off;
    logic                in_cnt;
    logic [ADDR_W-4:0]   cnt_ch;

    assign cnt_off = addr - A_CNT_BASE;
    assign in_cnt  = (int'(addr) >= int'(A_CNT_BASE)) && (int'(addr) < CNT_END)
                     && (addr[1:0] == 2'b00);
    assign cnt_ch  = cnt_off[ADDR_W-1:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            oe_q   <= '0;
            pre_q  <= '0;
            post_q <= '0;
            for (int n = 0; n < NUM_CH; n++) begin
                hi_q[n] <= '0;
                lo_q[n] <= '0;
            end
        end else if (wr_en) begin
            case (addr)
                A_SRC:   src_q  <= wr_data[SRC_BITS-1:0];
                A_OE:    oe_q   <= wr_data[OE_BITS-1:0];
                A_PRE:   pre_q  <= wr_data[NUM_CH-1:0];
                A_POST:  post_q <= wr_data[NUM_CH-1:0];
                default: ;
            endcase
            for (int n = 0; n < NUM_CH; n++) begin
                if (in_cnt && int'(cnt_ch) == n) begin
                    if (addr[2]) lo_q[n] <= wr_data[CNT_W-1:0];
                    else         hi_q[n] <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_SRC:   rd_data[SRC_BITS-1:0] = src_q;
            A_OE:    rd_data[OE_BITS-1:0]  = oe_q;
            A_PRE:   rd_data[NUM_CH-1:0]   = pre_q;
            A_POST:  rd_data[NUM_CH-1:0]   = post_q;
            default: ;
        endcase
        for (int n = 0; n < NUM_CH; n++) begin
            if (in_cnt && int'(cnt_ch) == n) begin
                rd_data[CNT_W-1:0] = addr[2] ? lo_q[n] : hi_q[n];
            end
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
        assign cfg[n].sel     = src_q[SEL_W*n +: SEL_W];
        assign cfg[n].bypass  = src_q[BYP_LSB + n];
        assign cfg[n].pre_en  = pre_q[n];
        assign cfg[n].post_en = post_q[n];
        assign cfg[n].out_en  = oe_q[n];
        assign cfg[n].hi_m1   = hi_q[n];
        assign cfg[n].lo_m1   = lo_q[n];
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  chan_cfg_t          cfg,
    input  logic [NUM_SRC-1:0] ticks,
    output logic               wave
);

    logic             tick;
    logic             run;
    logic             level;
    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_sh;
    logic [CNT_W-1:0] lo_sh;

    assign tick = pick_tick(cfg.sel, ticks);
    assign run  = cfg.pre_en && !cfg.bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            hi_sh   <= '0;
            lo_sh   <= '0;
        end else if (!run) begin
            // held at start of high phase; lengths track the registers
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            hi_sh   <= cfg.hi_m1;
            lo_sh   <= cfg.lo_m1;
        end else if (tick) begin
            if (phase_q == PH_HIGH) begin
                if (cnt_q == hi_sh) begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == lo_sh) begin
                    phase_q <= PH_HIGH;
                    cnt_q   <= '0;
                    hi_sh   <= cfg.hi_m1;
                    lo_sh   <= cfg.lo_m1;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign level = cfg.bypass ? tick : (phase_q == PH_HIGH);
    assign wave  = cfg.pre_en && cfg.post_en && cfg.out_en && level;

    // counter never runs past the active phase length
    assert_cnt_in_phase_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |-> (cnt_q <= hi_sh));
    assert_cnt_in_low_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (cnt_q <= lo_sh));

    // no selected tick: nothing moves
    assert_freeze_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $past(run && !tick) |-> ($stable(cnt_q) && $stable(phase_q)));

    // counter enable low pulls the channel to the start of high phase
    assert_pre_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg.pre_en |=> (cnt_q == '0 && phase_q == PH_HIGH));

    // lengths only change at a period boundary
    assert_shadow_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && cnt_q != '0) |-> ($stable(hi_sh) && $stable(lo_sh)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wr_data,
    output logic [DATA_W-1:0]   reg_rd_data,
    input  logic [NUM_SRC-1:0]  src_tick,
    output logic [NUM_CH-1:0]   pwm_out
);

    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_bank_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .cfg     (cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_bank_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg[n]),
            .ticks (src_tick),
            .wave  (pwm_out[n])
        );

        assert_gate_low_R6: assert property (@(posedge clk) disable iff (rst)
            !(cfg[n].post_en && cfg[n].out_en) |-> !pwm_out[n]);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0));

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [4:0]  src_tick = '0;
    logic [6:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit done = 0;

    // reference model state
    int m_src, m_oe, m_pre, m_post;
    int m_hi[NCH], m_lo[NCH];
    bit m_high[NCH];
    int m_rem[NCH], m_lat_hi[NCH], m_lat_lo[NCH];

    pwm_bank dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_read(input int a);
        if (a == 0)  return m_src;
        if (a == 4)  return m_oe;
        if (a == 8)  return m_pre;
        if (a == 12) return m_post;
        if (a >= 16 && a < 72 && (a % 4) == 0)
            return ((a % 8) == 4) ? m_lo[(a-16)/8] : m_hi[(a-16)/8];
        return 0;
    endfunction

    function automatic bit sel_tick(input int ch);
        int s;
        s = (m_src >> (3*ch)) & 7;
        if (s > 4) return 1'b0;
        return src_tick[s];
    endfunction

    task automatic check(input string tag, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, then advance the model to the next rising edge
    always @(negedge clk) begin
        if (rst) begin
            m_src = 0; m_oe = 0; m_pre = 0; m_post = 0;
            for (int c = 0; c < NCH; c++) begin
                m_hi[c] = 0; m_lo[c] = 0; m_high[c] = 1;
                m_rem[c] = 1; m_lat_hi[c] = 0; m_lat_lo[c] = 0;
            end
        end else begin
            check("R2", reg_rd_data, model_read(reg_addr), "read data");
            for (int c = 0; c < NCH; c++) begin
                bit en, byp, e;
                en  = ((m_pre >> c) & 1) && ((m_post >> c) & 1) && ((m_oe >> c) & 1);
                byp = (m_src >> (21 + c)) & 1;
                e   = en && (byp ? sel_tick(c) : m_high[c]);
                check(cur_tag, pwm_out[c], e, $sformatf("pwm_out[%0d]", c));
            end
            for (int c = 0; c < NCH; c++) begin
                bit byp;
                byp = (m_src >> (21 + c)) & 1;
                if (!((m_pre >> c) & 1) || byp) begin
                    m_high[c] = 1; m_lat_hi[c] = m_hi[c]; m_lat_lo[c] = m_lo[c];
                    m_rem[c] = m_hi[c] + 1;
                end else if (sel_tick(c)) begin
                    m_rem[c]--;
                    if (m_rem[c] == 0) begin
                        if (m_high[c]) begin
                            m_high[c] = 0; m_rem[c] = m_lat_lo[c] + 1;
                        end else begin
                            m_lat_hi[c] = m_hi[c]; m_lat_lo[c] = m_lo[c];
                            m_high[c] = 1; m_rem[c] = m_lat_hi[c] + 1;
                        end
                    end
                end
            end
            if (reg_wr_en) begin
                int a, d;
                a = reg_addr; d = reg_wr_data;
                if (a == 0)  m_src  = d & 32'h0FFF_FFFF;
                if (a == 4)  m_oe   = d & 32'h3FFF;
                if (a == 8)  m_pre  = d & 32'h7F;
                if (a == 12) m_post = d & 32'h7F;
                if (a >= 16 && a < 72 && (a % 4) == 0) begin
                    if ((a % 8) == 4) m_lo[(a-16)/8] = d & 32'hFFFF;
                    else              m_hi[(a-16)/8] = d & 32'hFFFF;
                end
            end
        end
    end

    // source tick patterns
    initial begin
        int cyc = 0;
        int lfsr = 8'h5A;
        forever begin
            @(posedge clk); #1;
            cyc++;
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
            src_tick[0] = 1'b1;
            src_tick[1] = (cyc % 2) == 0;
            src_tick[2] = (cyc % 3) == 0;
            src_tick[3] = lfsr[0];
            src_tick[4] = (cyc % 4) == 1;
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_addr = 8'(a); reg_wr_data = d; reg_wr_en = 1'b1;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = '0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        @(posedge clk); #1;
        reg_addr = 8'(a);
        @(negedge clk); #1;
        check(tag, reg_rd_data, exp, $sformatf("reg %0h", a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: registers and outputs after reset
        for (int a = 0; a < 80; a += 4) rd_chk("R1", a, 0);
        check("R1", pwm_out, 0, "pwm_out after reset");

        // R2: field widths, unmapped and unaligned addresses
        cur_tag = "R2";
        wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2", 8'h00, 32'h0FFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2", 8'h04, 32'h3FFF);
        wr(8'h44, 32'h1234_ABCD); rd_chk("R2", 8'h44, 32'hABCD);
        wr(8'h50, 32'hFFFF_FFFF); rd_chk("R2", 8'h50, 0);
        wr(8'h12, 32'h0000_7777); rd_chk("R2", 8'h10, 0);
        rd_chk("R2", 8'h12, 0);
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h44, 0);

        // R4: counting waveforms on three channels and sources
        cur_tag = "R4";
        wr(8'h00, (0 << 0) | (1 << 3) | (2 << 18));
        wr(8'h10, 2); wr(8'h14, 4);
        wr(8'h18, 0); wr(8'h1C, 0);
        wr(8'h40, 5); wr(8'h44, 1);
        wr(8'h08, 7'h43); wr(8'h0C, 7'h43); wr(8'h04, 7'h43);
        idle(120);

        // R8: new lengths mid-period wait for the next boundary
        cur_tag = "R8";
        idle(3);
        wr(8'h10, 1); wr(8'h14, 0);
        idle(40);
        wr(8'h40, 0);
        idle(40);

        // R5: counter enable low holds then restarts at high phase
        cur_tag = "R5";
        wr(8'h08, 7'h42); idle(10);
        wr(8'h08, 7'h43); idle(40);

        // R3: unused selector freezes, random source counts
        cur_tag = "R3";
        wr(8'h20, 1); wr(8'h24, 2);
        wr(8'h28, 0); wr(8'h2C, 3);
        wr(8'h00, (0 << 0) | (1 << 3) | (6 << 6) | (3 << 9) | (2 << 18));
        wr(8'h08, 7'h4F); wr(8'h0C, 7'h4F); wr(8'h04, 7'h4F);
        idle(60);

        // R7: bypass passes the selected tick through
        cur_tag = "R7";
        wr(8'h00, (0 << 0) | (1 << 3) | (6 << 6) | (3 << 9) | (4 << 12) | (3 << 15) | (2 << 18)
                  | (1 << 25) | (1 << 26));
        wr(8'h08, 7'h7F); wr(8'h0C, 7'h7F); wr(8'h04, 7'h7F);
        idle(60);

        // R6: each enable alone forces its output low
        cur_tag = "R6";
        wr(8'h04, 7'h7E); idle(20);
        wr(8'h0C, 7'h7C); idle(20);
        wr(8'h08, 7'h78); idle(20);
        check("R6", pwm_out[2:0], 0, "outputs 0..2 gated");

        // R9: transition-mode bits stored but inert
        cur_tag = "R9";
        wr(8'h04, 32'h3F80); rd_chk("R9", 8'h04, 32'h3F80);
        idle(5);
        check("R9", pwm_out, 0, "outputs with only transition-mode bits");
        wr(8'h04, 32'h3FFF); idle(30);
        rd_chk("R9", 8'h04, 32'h3FFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule